// File: doc/BRIEF.md
# VLAN Table Command Engine

This block owns a 4096-entry VLAN table and gives software a small register window onto it. The table is never addressed word by word. Software fills two staging words and then writes a command that names a VID and an operation. There are two such words. The first holds the entry's valid flag, its member set and two per-VLAN flags: independent learning and egress tag enable. The second holds a 2-bit egress tag code for each port. The engine raises busy and spends a fixed number of cycles on the table access, then drops busy. A write command copies the staging words into the entry. A read command copies the entry back into the staging words.

A separate read-only lookup port serves the forwarding path. It returns the stored fields of any VID in the same cycle, without involving the command machinery. A command with an unknown operation code is refused at once and reported through an invalid flag in the command register.

Top module: `vlan_tbl_engine`

## Requirements
- R1: After reset, busy and invalid read 0 and both staging words read 0. Every VID reads back as all-zero data and misses on the lookup port.
- R2: A command write with operation code 1 stores the staging words into the entry of the given VID. In the command register the VID sits in bits 11:0, the operation code in bits 15:12 and busy in bit 31.
- R3: An accepted command keeps busy (bit 31) at 1 for exactly ACC_LAT clock cycles (4 by default), starting on the cycle after the command write. Its result is visible once busy reads 0.
- R4: A command with operation code 0 loads both staging words from the entry of the given VID. Register bits that carry no field always read 0.
- R5: Any operation code other than 0 or 1 never sets busy. It sets invalid (bit 16) on the next cycle and changes neither the table nor the staging words. The next accepted command clears invalid.
- R6: A write to the command register while busy is 1 is ignored. The VID, the operation code and the remaining busy time stay as they were.
- R7: A write to either staging word while busy is 1 is ignored.
- R8: The lookup port shows the stored valid bit as hit, together with the members, egress codes, learning flag and tag flag of the VID it is given. It shows the old contents until the cycle in which busy clears after a write.
- R9: First staging word layout: bit 0 valid, bits 23:16 member set (bit n is port n), bit 28 egress tag enable, bit 30 independent learning. Second staging word: port n's egress code (0 untag, 2 tag, 3 stack) in bits 2n+1:2n, stored verbatim.
- R10: Writing all-zero staging words into an entry clears it. Later reads return zeros and the lookup port misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 command, 1 first staging word, 2 second staging word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_vid | input | 12 | VID queried by the forwarding path |
| lk_hit | output | 1 | Valid bit of the queried entry |
| lk_members | output | 8 | Member set of the queried entry |
| lk_etag | output | 16 | Per-port egress codes of the queried entry |
| lk_ivl | output | 1 | Independent learning flag of the queried entry |
| lk_vtag | output | 1 | Egress tag enable flag of the queried entry |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the completion of a table write and a forwarding lookup of the same VID. The bench holds the lookup on that VID through every busy cycle. It expects the old contents while busy reads 1 and the new contents on the first cycle busy reads 0.

The second pair is a running command and a fresh register write. The bench issues a command or a staging write in the middle of a busy window. It then judges from the busy count and the later readback that neither the command nor the stored entry was altered.

// File: rtl/vtbl_pkg.sv
`timescale 1ns/1ps
package vtbl_pkg;
    // register select codes
    localparam logic [1:0] ADDR_CMD = 2'd0;
    localparam logic [1:0] ADDR_D1  = 2'd1;
    localparam logic [1:0] ADDR_D2  = 2'd2;

    // operation codes
    localparam logic [3:0] OP_READ  = 4'd0;
    localparam logic [3:0] OP_WRITE = 4'd1;

    // command register bit positions
    localparam int CMD_BUSY_BIT = 31;
    localparam int CMD_INV_BIT  = 16;
    localparam int CMD_OP_LSB   = 12;

    // first staging word bit positions
    localparam int D1_VALID_BIT = 0;
    localparam int D1_MEM_LSB   = 16;
    localparam int D1_VTAG_BIT  = 28;
    localparam int D1_IVL_BIT   = 30;
endpackage

// File: rtl/vtbl_store.sv
`timescale 1ns/1ps
module vtbl_store #(
    parameter int VID_W = 12,
    parameter int EW    = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VID_W-1:0] wvid,
    input  logic [EW-1:0]    wdata,
    input  logic [VID_W-1:0] rvid,
    output logic [EW-1:0]    rdata,
    input  logic [VID_W-1:0] lvid,
    output logic [EW-1:0]    ldata
);
    localparam int DEPTH = 1 << VID_W;

    logic [EW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] used_q;
    logic [DEPTH-1:0] used_d;

    always_comb begin
        used_d = used_q;
        if (we) used_d[wvid] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[wvid] <= wdata;
    end

    assign rdata = used_q[rvid] ? mem[rvid] : '0;
    assign ldata = used_q[lvid] ? mem[lvid] : '0;

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rvid == wvid) |=> (rdata == $past(wdata)))
        else $error("stored entry not visible"); // R2
endmodule

// File: rtl/vtbl_ctrl.sv
`timescale 1ns/1ps
module vtbl_ctrl
    import vtbl_pkg::*;
#(
    parameter int VID_W   = 12,
    parameter int NPORT   = 8,
    parameter int ACC_LAT = 4,
    parameter int EW      = 3 + 3 * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             tbl_we,
    output logic [VID_W-1:0] tbl_vid,
    output logic [EW-1:0]    tbl_wdata,
    input  logic [EW-1:0]    tbl_rdata
);
    localparam int CW = $clog2(ACC_LAT + 1);
    localparam int TW = 2 * NPORT;

    typedef struct packed {
        logic             busy;
        logic             invalid;
        logic [3:0]       op;
        logic [VID_W-1:0] vid;
        logic [CW-1:0]    cnt;
        logic             valid;
        logic [NPORT-1:0] members;
        logic             vtag;
        logic             ivl;
        logic [TW-1:0]    etag;
    } ctrl_t;

    ctrl_t q, d;
    logic  op_ok;
    logic  last;
    logic  unused_wbits;

    assign unused_wbits = ^cfg_wdata;
    assign op_ok = (cfg_wdata[CMD_OP_LSB +: 4] == OP_READ) ||
                   (cfg_wdata[CMD_OP_LSB +: 4] == OP_WRITE);
    assign last  = (q.cnt == CW'(ACC_LAT - 1));

    always_comb begin
        d      = q;
        tbl_we = 1'b0;
        if (q.busy) begin
            if (last) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                if (q.op == OP_WRITE) begin
                    tbl_we = 1'b1;
                end else begin
                    d.valid   = tbl_rdata[0];
                    d.members = tbl_rdata[1 +: NPORT];
                    d.vtag    = tbl_rdata[NPORT + 1];
                    d.ivl     = tbl_rdata[NPORT + 2];
                    d.etag    = tbl_rdata[NPORT + 3 +: TW];
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_CMD: begin
                    d.op  = cfg_wdata[CMD_OP_LSB +: 4];
                    d.vid = cfg_wdata[VID_W-1:0];
                    d.cnt = '0;
                    if (op_ok) begin
                        d.busy    = 1'b1;
                        d.invalid = 1'b0;
                    end else begin
                        d.invalid = 1'b1;
                    end
                end
                ADDR_D1: begin
                    d.valid   = cfg_wdata[D1_VALID_BIT];
                    d.members = cfg_wdata[D1_MEM_LSB +: NPORT];
                    d.vtag    = cfg_wdata[D1_VTAG_BIT];
                    d.ivl     = cfg_wdata[D1_IVL_BIT];
                end
                ADDR_D2: d.etag = cfg_wdata[TW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tbl_vid   = q.vid;
    assign tbl_wdata = {q.etag, q.ivl, q.vtag, q.members, q.valid};

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_CMD: begin
                cfg_rdata[CMD_BUSY_BIT]       = q.busy;
                cfg_rdata[CMD_INV_BIT]        = q.invalid;
                cfg_rdata[CMD_OP_LSB +: 4]    = q.op;
                cfg_rdata[VID_W-1:0]          = q.vid;
            end
            ADDR_D1: begin
                cfg_rdata[D1_VALID_BIT]       = q.valid;
                cfg_rdata[D1_MEM_LSB +: NPORT] = q.members;
                cfg_rdata[D1_VTAG_BIT]        = q.vtag;
                cfg_rdata[D1_IVL_BIT]         = q.ivl;
            end
            ADDR_D2: cfg_rdata[TW-1:0] = q.etag;
            default: ;
        endcase
    end

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(cfg_we && cfg_addr == ADDR_CMD && op_ok))
        else $error("busy rose without command"); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CW'(ACC_LAT))
        else $error("latency counter overrun"); // R3
    AST_WE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> !q.busy)
        else $error("busy held after table write"); // R3
    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_CMD && !q.busy && !op_ok) |=> (!q.busy && q.invalid))
        else $error("bad operation not refused"); // R5
    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && cfg_we) |=> ($stable(q.vid) && $stable(q.op)))
        else $error("command changed while busy"); // R6
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.op == OP_WRITE) |=> ($stable(q.etag) && $stable(q.members) && $stable(q.valid)))
        else $error("staging changed during write"); // R7
endmodule

// File: rtl/vlan_tbl_engine.sv
`timescale 1ns/1ps
module vlan_tbl_engine #(
    parameter int VID_W   = 12,
    parameter int NPORT   = 8,
    parameter int ACC_LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [VID_W-1:0]     lk_vid,
    output logic                 lk_hit,
    output logic [NPORT-1:0]     lk_members,
    output logic [2*NPORT-1:0]   lk_etag,
    output logic                 lk_ivl,
    output logic                 lk_vtag
);
    localparam int EW = 3 + 3 * NPORT;

    logic             tbl_we;
    logic [VID_W-1:0] tbl_vid;
    logic [EW-1:0]    tbl_wdata;
    logic [EW-1:0]    tbl_rdata;
    logic [EW-1:0]    lk_data;

    vtbl_ctrl #(.VID_W(VID_W), .NPORT(NPORT), .ACC_LAT(ACC_LAT), .EW(EW)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tbl_we(tbl_we), .tbl_vid(tbl_vid), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    vtbl_store #(.VID_W(VID_W), .EW(EW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .wvid(tbl_vid), .wdata(tbl_wdata),
        .rvid(tbl_vid), .rdata(tbl_rdata),
        .lvid(lk_vid), .ldata(lk_data)
    );

    assign lk_hit     = lk_data[0];
    assign lk_members = lk_data[1 +: NPORT];
    assign lk_vtag    = lk_data[NPORT + 1];
    assign lk_ivl     = lk_data[NPORT + 2];
    assign lk_etag    = lk_data[NPORT + 3 +: 2*NPORT];
endmodule

// File: tb/vlan_tbl_engine_tb_top.sv
`timescale 1ns/1ps
module vlan_tbl_engine_tb_top;
    localparam logic [1:0] A_CMD = 2'd0;
    localparam logic [1:0] A_D1  = 2'd1;
    localparam logic [1:0] A_D2  = 2'd2;
    localparam logic [31:0] D1_MASK = 32'h50FF_0001;
    localparam logic [31:0] D2_MASK = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [11:0] lk_vid = '0;
    logic        lk_hit;
    logic [7:0]  lk_members;
    logic [15:0] lk_etag;
    logic        lk_ivl;
    logic        lk_vtag;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m1 [int];
    logic [31:0] m2 [int];
    logic [31:0] st1 = '0;
    logic [31:0] st2 = '0;
    logic        inv_m = 1'b0;

    always #10 clk = ~clk;

    vlan_tbl_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_vid(lk_vid),
        .lk_hit(lk_hit), .lk_members(lk_members), .lk_etag(lk_etag),
        .lk_ivl(lk_ivl), .lk_vtag(lk_vtag)
    );

    function automatic logic [31:0] ent1(input int v);
        return m1.exists(v) ? m1[v] : 32'h0;
    endfunction
    function automatic logic [31:0] ent2(input int v);
        return m2.exists(v) ? m2[v] : 32'h0;
    endfunction
    function automatic logic [31:0] cmd_word(input logic [3:0] op, input logic [11:0] vid);
        return {16'h0, op, vid};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] dat);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = dat;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] dat);
        cfg_addr = a;
        #1;
        dat = cfg_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] r;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            reg_rd(A_CMD, r);
            if (!r[31]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic lk_chk(input string req, input int v, input logic [31:0] e1, input logic [31:0] e2);
        lk_vid = v[11:0];
        #1;
        chk(req, "lookup flags", {21'h0, lk_ivl, lk_vtag, lk_members, lk_hit},
            {21'h0, e1[30], e1[28], e1[23:16], e1[0]});
        chk(req, "lookup etag", {16'h0, lk_etag}, e2 & D2_MASK);
    endtask

    task automatic do_write(input logic [11:0] vid, input logic [31:0] d1, input logic [31:0] d2);
        int n;
        reg_wr(A_D1, d1);
        reg_wr(A_D2, d2);
        st1 = d1 & D1_MASK; st2 = d2 & D2_MASK;
        reg_wr(A_CMD, cmd_word(4'd1, vid));
        wait_idle(n);
        chk("R3", "write busy cycles", n, 4);
        m1[vid] = st1; m2[vid] = st2; inv_m = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] vid, input string req);
        int n;
        logic [31:0] r;
        reg_wr(A_CMD, cmd_word(4'd0, vid));
        wait_idle(n);
        chk("R3", "read busy cycles", n, 4);
        st1 = ent1(vid); st2 = ent2(vid); inv_m = 1'b0;
        reg_rd(A_D1, r); chk(req, "read word1", r, st1);
        reg_rd(A_D2, r); chk(req, "read word2", r, st2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R3 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(A_CMD, r); chk("R1", "cmd after reset", r, 32'h0);
        reg_rd(A_D1, r);  chk("R1", "word1 after reset", r, 32'h0);
        reg_rd(A_D2, r);  chk("R1", "word2 after reset", r, 32'h0);
        lk_chk("R1", 12'hABC, 32'h0, 32'h0);
        do_read(12'hABC, "R1");

        // R4 R9 undefined bits masked in staging
        reg_wr(A_D1, 32'hFFFF_FFFF);
        reg_rd(A_D1, r); chk("R4", "word1 masked", r, D1_MASK);
        reg_wr(A_D2, 32'hFFFF_C8E3);
        reg_rd(A_D2, r); chk("R9", "word2 masked", r, 32'h0000_C8E3);

        // R8 collision: lookup of VID 5 while its write completes
        reg_wr(A_CMD, cmd_word(4'd1, 12'd5));
        lk_vid = 12'd5;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R8", "lookup old during busy", {31'h0, lk_hit}, 32'h0);
            reg_rd(A_CMD, r); chk("R3", "busy held", {31'h0, r[31]}, 32'h1);
            @(negedge clk);
        end
        reg_rd(A_CMD, r); chk("R3", "busy cleared", {31'h0, r[31]}, 32'h0);
        m1[5] = D1_MASK; m2[5] = 32'hC8E3;
        lk_chk("R8", 5, D1_MASK, 32'hC8E3);

        // R2 R4 R9 readback after clearing staging
        reg_wr(A_D1, 32'h0); reg_wr(A_D2, 32'h0);
        do_read(12'd5, "R2");

        // R5 bad operation code
        reg_wr(A_CMD, cmd_word(4'd5, 12'd5));
        reg_rd(A_CMD, r); chk("R5", "bad op status", r, 32'h0001_5005);
        reg_rd(A_D1, r);  chk("R5", "staging kept", r, D1_MASK);
        do_read(12'd5, "R5");
        reg_rd(A_CMD, r); chk("R5", "invalid cleared", r, 32'h0000_0005);

        // R6 command write during busy is ignored
        reg_wr(A_CMD, cmd_word(4'd0, 12'd7));
        reg_wr(A_CMD, cmd_word(4'd1, 12'd5));
        wait_idle(n);
        chk("R6", "remaining busy cycles", n, 2);
        reg_rd(A_CMD, r); chk("R6", "cmd kept", r, 32'h0000_0007);
        reg_rd(A_D1, r);  chk("R6", "read of vid7", r, 32'h0);
        lk_chk("R6", 5, D1_MASK, 32'hC8E3);

        // R7 staging write during busy is ignored
        reg_wr(A_D1, 32'h0000_0001); reg_wr(A_D2, 32'h0000_0003);
        reg_wr(A_CMD, cmd_word(4'd1, 12'd9));
        reg_wr(A_D1, 32'h0);
        reg_wr(A_D2, 32'h0);
        wait_idle(n);
        m1[9] = 32'h1; m2[9] = 32'h3;
        lk_chk("R7", 9, 32'h1, 32'h3);
        reg_rd(A_D1, r); chk("R7", "word1 unchanged", r, 32'h1);

        // R10 all-zero write clears entry
        do_write(12'd5, 32'h0, 32'h0);
        lk_chk("R10", 5, 32'h0, 32'h0);
        reg_wr(A_D1, 32'hFFFF_FFFF);
        do_read(12'd5, "R10");

        // random mix
        for (int i = 0; i < 150; i++) begin
            logic [11:0] vid;
            int op;
            vid = 12'(($urandom % 16) * 257);
            op  = $urandom % 4;
            if (op < 2) begin
                do_write(vid, $urandom, $urandom);
            end else if (op == 2) begin
                do_read(vid, "R4");
            end else begin
                logic [3:0] bop;
                bop = 4'(2 + ($urandom % 14));
                reg_wr(A_CMD, cmd_word(bop, vid));
                reg_rd(A_CMD, r);
                chk("R5", "random bad op", r, {15'h0, 1'b1, bop, vid});
                reg_rd(A_D1, r); chk("R5", "random staging kept", r, st1);
            end
            lk_chk("R8", int'(vid), ent1(int'(vid)), ent2(int'(vid)));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule